// File: doc/BRIEF.md
# SPI Serial Memory Target Controller

This block is the device end of a byte-addressed serial memory that is reached over a four-wire SPI link. A host pulls chip select low, shifts in one command byte and then any address or data that command needs. The block answers on a serial output that it drives only while it has something to send. Every SPI pin is oversampled by the block's own system clock through a short synchronizer, and SCK edges are found in that clock domain. The SPI clock therefore has to run a few times slower than the system clock.

Storage is modelled inside the block as two flop arrays. One is a main array whose size is set by a parameter. The other is a separate 128-byte identification page. A three-bit status register governs access:
- a write-enable latch, which must be set before any change to memory or to the status register;
- a page-select bit, which sends READ and WRITE to the identification page;
- a protect bit, which together with a low write-protect pin locks the status register.

A pause input freezes a transfer partway through a session and later resumes it. Write data is collected in a small page buffer. It is committed to the arrays one byte per system clock after chip select rises, and only when the session ended on a byte boundary.

Top module: `serial_mem_target`

## Requirements
- R1: SI is sampled on SCK rising edges and SO changes only after SCK falling edges. Sessions work the same whether SCK idles low (mode 0) or high (mode 3).
- R2: While cs_n is high, so_oe is 0. Each session starts at a cs_n falling edge with a fresh command byte.
- R3: Command byte values are 0x01 status write, 0x02 data write, 0x03 data read, 0x04 clear write enable, 0x05 status read and 0x06 set write enable. Any other first byte makes the block ignore the rest of the session: SO stays undriven and no state changes.
- R4: A data write or status write has effect only when the write-enable latch is set. 0x06 sets the latch and 0x04 clears it.
- R5: While wp_n is 0 and the protect bit is 1, a status write leaves the status unchanged. With wp_n at 1 the status write is accepted.
- R6: hold_n taken low while SCK is low makes the block ignore SCK and sets so_oe to 0. Taking hold_n high while SCK is low resumes the transfer at the same bit.
- R7: With the page-select bit at 1, READ and WRITE use the identification page indexed by address bits [6:0]. The main array is untouched.
- R8: A data read is 0x03 followed by a 16-bit address, MSB first. Data bytes then follow on SO, MSB first, from that address onward.
- R9: The address increments after each byte and wraps from MAIN_BYTES-1 to 0 (main array index = address mod MAIN_BYTES). This applies to reads and to buffered writes.
- R10: Write data is committed only after cs_n rises, and only if a whole number of data bytes was received. A session ending on a partial byte writes nothing and keeps the write-enable latch.
- R11: The write-enable latch clears after a data write commits and after an accepted status write.
- R12: The status byte has the protect bit in bit 7, page-select in bit 6 and the write-enable latch in bit 1; all other bits read 0. A status read repeats this byte for as long as SCK runs. A status write takes bits 7 and 6 of its data byte.
- R13: At most PAGE_BYTES data bytes are taken per write session. Further bytes are discarded.
- R14: After reset the status byte is 0x00, both arrays read 0xFF and so_oe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data from the host |
| wp_n | input | 1 | Active-low write protect for the status register |
| hold_n | input | 1 | Active-low pause of the current transfer |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for so; 0 means high impedance |

## Verification
Data writes followed by readback use a table of addresses and data values. The table mixes both SCK idle levels, so that a fault in edge selection shows up as shifted or corrupted bytes in only one mode. Directed sessions then vary the command stream:
- missing or cleared write enable, an unknown command byte and a partial final byte, which together separate "no write happened" from "wrong data written";
- an overlong page and an address at the top of the array, which expose errors in the byte cap and in wrap-around;
- repeated status reads, page-select toggling and the protect lock under both wp_n levels, which show whether status bits sit in the right positions and gate the right operations.

A pause placed inside an address byte and inside a data byte shows whether the shift state survives the pause intact.

// File: rtl/smt_pkg.sv
package smt_pkg;

    localparam logic [7:0] OP_WR_STATUS = 8'h01;
    localparam logic [7:0] OP_WRITE     = 8'h02;
    localparam logic [7:0] OP_READ      = 8'h03;
    localparam logic [7:0] OP_WEL_CLR   = 8'h04;
    localparam logic [7:0] OP_RD_STATUS = 8'h05;
    localparam logic [7:0] OP_WEL_SET   = 8'h06;

    // Session phase: which kind of byte the next eight SCK rises build.
    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_RDATA,
        PH_WDATA,
        PH_RSTAT,
        PH_WSTAT,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic wpen;   // protect bit, locks status when wp_n is low
        logic ipl;    // page select: identification page
        logic wel;    // write-enable latch
    } status_t;

    function automatic logic [7:0] status_byte(status_t s);
        return {s.wpen, s.ipl, 4'b0000, s.wel, 1'b0};
    endfunction

endpackage

// File: rtl/smt_sync.sv
module smt_sync #(
    parameter int              WIDTH     = 1,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) pipe[0] <= RESET_VAL;
                else     pipe[0] <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) pipe <= {STAGES{RESET_VAL}};
                else     pipe <= {pipe[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/smt_store.sv
module smt_store #(
    parameter int MAIN_BYTES = 256,
    parameter int ID_BYTES   = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic        we_id,
    input  logic [15:0] waddr,
    input  logic [7:0]  wdata,
    input  logic [15:0] raddr,
    input  logic        rd_id,
    output logic [7:0]  rdata
);

    localparam int MAIN_AW = $clog2(MAIN_BYTES);
    localparam int ID_AW   = $clog2(ID_BYTES);

    logic [7:0] main_mem [MAIN_BYTES];
    logic [7:0] id_mem   [ID_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MAIN_BYTES; i++) main_mem[i] <= 8'hFF;
            for (int j = 0; j < ID_BYTES; j++)   id_mem[j]   <= 8'hFF;
        end else if (we) begin
            if (we_id) id_mem[waddr[ID_AW-1:0]]     <= wdata;
            else       main_mem[waddr[MAIN_AW-1:0]] <= wdata;
        end
    end

    assign rdata = rd_id ? id_mem[raddr[ID_AW-1:0]] : main_mem[raddr[MAIN_AW-1:0]];

    logic unused_addr_bits;
    assign unused_addr_bits = ^{raddr[15:MAIN_AW], waddr[15:MAIN_AW]};

endmodule

// File: rtl/smt_status.sv
module smt_status
    import smt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       set_wel,
    input  logic       clr_wel,
    input  logic       wr_req,
    input  logic [7:0] wr_data,
    input  logic       wp_n,
    output status_t    st
);

    logic locked;
    assign locked = st.wpen && !wp_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (wr_req && st.wel && !locked) begin
            st.wpen <= wr_data[7];
            st.ipl  <= wr_data[6];
            st.wel  <= 1'b0;
        end else if (clr_wel) begin
            st.wel <= 1'b0;
        end else if (set_wel) begin
            st.wel <= 1'b1;
        end
    end

    logic unused_data_bits;
    assign unused_data_bits = ^wr_data[5:0];

endmodule

// File: rtl/serial_mem_target.sv
module serial_mem_target
    import smt_pkg::*;
#(
    parameter int MAIN_BYTES  = 256,
    parameter int ID_BYTES    = 128,
    parameter int PAGE_BYTES  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    input  logic wp_n,
    input  logic hold_n,
    output logic so,
    output logic so_oe
);

    localparam int PAGE_AW = $clog2(PAGE_BYTES);
    localparam int PAGE_CW = $clog2(PAGE_BYTES + 1);
    localparam logic [PAGE_CW-1:0] PAGE_LIMIT = PAGE_CW'(PAGE_BYTES);

    // ---------------- input synchronization ----------------
    logic [4:0] pins_raw, pins_s;
    logic       sck_s, cs_n_s, si_s, wp_n_s, hold_n_s;

    assign pins_raw = {sck, cs_n, si, wp_n, hold_n};

    smt_sync #(.WIDTH(5), .STAGES(SYNC_STAGES), .RESET_VAL(5'b01011)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    assign {sck_s, cs_n_s, si_s, wp_n_s, hold_n_s} = pins_s;

    // ---------------- edge detection and pause ----------------
    logic sck_q, cs_q, hold_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= 1'b0;
            cs_q     <= 1'b1;
            hold_act <= 1'b0;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_n_s;
            if (cs_n_s)      hold_act <= 1'b0;
            else if (!sck_s) hold_act <= !hold_n_s;
        end
    end

    logic active, sck_rise, sck_fall, cs_fall, cs_rise;
    assign active   = !cs_n_s && !hold_act;
    assign sck_rise = active && sck_s && !sck_q;
    assign sck_fall = active && !sck_s && sck_q;
    assign cs_fall  = cs_q && !cs_n_s;
    assign cs_rise  = !cs_q && cs_n_s;

    // ---------------- session state ----------------
    phase_e             phase;
    logic [2:0]         bit_cnt;
    logic [6:0]         shreg;
    logic               is_read, addr_half, use_id, st_got, drive;
    logic [7:0]         addr_hi, tx, st_data;
    logic [15:0]        cur_addr, wr_base;
    logic [PAGE_CW-1:0] pend_cnt;
    logic [7:0]         wbuf [PAGE_BYTES];
    logic               so_q;

    logic [7:0] byte_in;
    logic       byte_done;
    assign byte_in   = {shreg, si_s};
    assign byte_done = sck_rise && (bit_cnt == 3'd7);

    // ---------------- status register ----------------
    status_t st_q;
    logic    op_set_wel, op_clr_wel, wsr_req, clr_wel;

    // ---------------- commit engine ----------------
    logic               com_busy, com_id, com_start, com_last;
    logic [PAGE_CW-1:0] com_idx, com_cnt;
    logic [15:0]        com_base;

    assign op_set_wel = byte_done && (phase == PH_CMD) && (byte_in == OP_WEL_SET);
    assign op_clr_wel = byte_done && (phase == PH_CMD) && (byte_in == OP_WEL_CLR);
    assign wsr_req    = cs_rise && (phase == PH_WSTAT) && (bit_cnt == 3'd0) && st_got;
    assign com_start  = cs_rise && (phase == PH_WDATA) && (bit_cnt == 3'd0)
                        && (pend_cnt != '0) && st_q.wel && !com_busy;
    assign com_last   = com_busy && ((com_idx + PAGE_CW'(1)) == com_cnt);
    assign clr_wel    = op_clr_wel || com_last;

    smt_status u_status (
        .clk     (clk),
        .rst     (rst),
        .set_wel (op_set_wel),
        .clr_wel (clr_wel),
        .wr_req  (wsr_req),
        .wr_data (st_data),
        .wp_n    (wp_n_s),
        .st      (st_q)
    );

    // ---------------- storage ----------------
    logic [15:0] rd_addr_sel;
    logic        rd_id_sel;
    logic [7:0]  rdata;
    logic [15:0] com_waddr;

    assign rd_addr_sel = (phase == PH_ADDR) ? {addr_hi, byte_in} : cur_addr;
    assign rd_id_sel   = (phase == PH_ADDR) ? st_q.ipl : use_id;
    assign com_waddr   = com_base + 16'(com_idx);

    smt_store #(.MAIN_BYTES(MAIN_BYTES), .ID_BYTES(ID_BYTES)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (com_busy),
        .we_id (com_id),
        .waddr (com_waddr),
        .wdata (wbuf[com_idx[PAGE_AW-1:0]]),
        .raddr (rd_addr_sel),
        .rd_id (rd_id_sel),
        .rdata (rdata)
    );

    // ---------------- protocol engine ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_SKIP;
            bit_cnt   <= '0;
            shreg     <= '0;
            is_read   <= 1'b0;
            addr_half <= 1'b0;
            use_id    <= 1'b0;
            st_got    <= 1'b0;
            drive     <= 1'b0;
            addr_hi   <= '0;
            tx        <= '0;
            st_data   <= '0;
            cur_addr  <= '0;
            wr_base   <= '0;
            pend_cnt  <= '0;
            so_q      <= 1'b0;
            for (int i = 0; i < PAGE_BYTES; i++) wbuf[i] <= '0;
        end else begin
            if (cs_fall) begin
                phase     <= PH_CMD;
                bit_cnt   <= '0;
                addr_half <= 1'b0;
                pend_cnt  <= '0;
                st_got    <= 1'b0;
                drive     <= 1'b0;
            end else if (sck_rise) begin
                shreg   <= byte_in[6:0];
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    case (phase)
                        PH_CMD: begin
                            case (byte_in)
                                OP_RD_STATUS: begin
                                    phase <= PH_RSTAT;
                                    tx    <= status_byte(st_q);
                                end
                                OP_WR_STATUS: phase <= PH_WSTAT;
                                OP_READ: begin
                                    phase   <= PH_ADDR;
                                    is_read <= 1'b1;
                                end
                                OP_WRITE: begin
                                    phase   <= PH_ADDR;
                                    is_read <= 1'b0;
                                end
                                default: phase <= PH_SKIP;
                            endcase
                        end
                        PH_ADDR: begin
                            if (!addr_half) begin
                                addr_hi   <= byte_in;
                                addr_half <= 1'b1;
                            end else begin
                                use_id <= st_q.ipl;
                                if (is_read) begin
                                    tx       <= rdata;
                                    cur_addr <= rd_addr_sel + 16'd1;
                                    phase    <= PH_RDATA;
                                end else begin
                                    wr_base <= rd_addr_sel;
                                    phase   <= PH_WDATA;
                                end
                            end
                        end
                        PH_RDATA: begin
                            tx       <= rdata;
                            cur_addr <= cur_addr + 16'd1;
                        end
                        PH_RSTAT: tx <= status_byte(st_q);
                        PH_WDATA: begin
                            if (pend_cnt < PAGE_LIMIT) begin
                                wbuf[pend_cnt[PAGE_AW-1:0]] <= byte_in;
                                pend_cnt <= pend_cnt + PAGE_CW'(1);
                            end
                        end
                        PH_WSTAT: begin
                            if (!st_got) begin
                                st_data <= byte_in;
                                st_got  <= 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end else if (sck_fall) begin
                if (phase == PH_RDATA || phase == PH_RSTAT) begin
                    so_q  <= tx[7];
                    tx    <= {tx[6:0], 1'b0};
                    drive <= 1'b1;
                end
            end
            if (cs_n_s) drive <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            com_busy <= 1'b0;
            com_id   <= 1'b0;
            com_idx  <= '0;
            com_cnt  <= '0;
            com_base <= '0;
        end else if (com_start) begin
            com_busy <= 1'b1;
            com_id   <= use_id;
            com_idx  <= '0;
            com_cnt  <= pend_cnt;
            com_base <= wr_base;
        end else if (com_busy) begin
            com_idx <= com_idx + PAGE_CW'(1);
            if (com_last) com_busy <= 1'b0;
        end
    end

    assign so    = so_q;
    assign so_oe = drive && !cs_n_s && !hold_act;

endmodule

// File: rtl/smt_checker.sv
module smt_checker
    import smt_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int PAGE_CW    = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               so,
    input logic               so_oe,
    input logic               sck_fall,
    input phase_e             phase,
    input logic               store_we,
    input status_t            st,
    input logic               wp_n_s,
    input logic               hold_act,
    input logic [2:0]         bit_cnt,
    input logic [PAGE_CW-1:0] pend_cnt,
    input logic               com_busy
);

    assert_so_on_fall_R1: assert property (@(posedge clk) disable iff (rst)
        !$stable(so) |-> $past(sck_fall));

    assert_skip_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP) |-> !so_oe);

    assert_wel_needed_R4: assert property (@(posedge clk) disable iff (rst)
        store_we |-> st.wel);

    assert_status_lock_R5: assert property (@(posedge clk) disable iff (rst)
        (st.wpen && !wp_n_s) |=> ($stable(st.wpen) && $stable(st.ipl)));

    assert_hold_freeze_R6: assert property (@(posedge clk) disable iff (rst)
        (hold_act && $past(hold_act)) |-> ($stable(bit_cnt) && $stable(phase)));

    assert_wel_clear_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(com_busy) |-> !st.wel);

    assert_page_cap_R13: assert property (@(posedge clk) disable iff (rst)
        pend_cnt <= PAGE_CW'(PAGE_BYTES));

endmodule

bind serial_mem_target smt_checker #(
    .PAGE_BYTES (PAGE_BYTES),
    .PAGE_CW    (PAGE_CW)
) u_checker (
    .clk      (clk),
    .rst      (rst),
    .so       (so),
    .so_oe    (so_oe),
    .sck_fall (sck_fall),
    .phase    (phase),
    .store_we (com_busy),
    .st       (st_q),
    .wp_n_s   (wp_n_s),
    .hold_act (hold_act),
    .bit_cnt  (bit_cnt),
    .pend_cnt (pend_cnt),
    .com_busy (com_busy)
);

// File: tb/serial_mem_target_bench.sv
module serial_mem_target_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HP         = 6;
    localparam int MAIN_BYTES = 256;
    localparam int PAGE_BYTES = 16;

    // {mode3, address, data}
    localparam logic [24:0] VEC [6] = '{
        {1'b0, 16'h0001, 8'h11},
        {1'b1, 16'h0002, 8'h22},
        {1'b0, 16'h0010, 8'hA5},
        {1'b1, 16'h00F0, 8'h5A},
        {1'b0, 16'h1234, 8'h00},
        {1'b1, 16'h0081, 8'h3C}
    };

    logic clk = 1'b0;
    logic rst, sck, cs_n, si, wp_n, hold_n;
    logic so, so_oe;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    bit  mode3  = 1'b0;
    bit  oe_seen;
    logic [7:0] r;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_mem_target #(
        .MAIN_BYTES (MAIN_BYTES),
        .ID_BYTES   (128),
        .PAGE_BYTES (PAGE_BYTES),
        .SYNC_STAGES(2)
    ) u_serial_mem_target (
        .clk    (clk),
        .rst    (rst),
        .sck    (sck),
        .cs_n   (cs_n),
        .si     (si),
        .wp_n   (wp_n),
        .hold_n (hold_n),
        .so     (so),
        .so_oe  (so_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cs_begin();
        sck = mode3;
        tick(HP);
        cs_n = 1'b0;
        oe_seen = 1'b0;
        tick(HP);
    endtask

    task automatic cs_end();
        tick(HP);
        cs_n = 1'b1;
        tick(4 * HP + PAGE_BYTES + 8);
    endtask

    task automatic do_hold();
        hold_n = 1'b0;
        tick(HP);
        chk("R6 so_oe during pause", {31'd0, so_oe}, 32'd0);
        for (int k = 0; k < 2; k++) begin
            si  = ~si;
            sck = 1'b1;
            tick(HP);
            sck = 1'b0;
            tick(HP);
        end
        hold_n = 1'b1;
        tick(HP);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, input int hold_at,
                        output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < nbits; i++) begin
            if (i == hold_at) do_hold();
            if (mode3) sck = 1'b0;
            si = tx[7 - i];
            tick(HP);
            rx = {rx[6:0], so};
            if (so_oe) oe_seen = 1'b1;
            sck = 1'b1;
            tick(HP);
            if (!mode3) sck = 1'b0;
        end
    endtask

    task automatic send_op(input logic [7:0] op);
        logic [7:0] d;
        cs_begin();
        xfer(op, 8, -1, d);
        cs_end();
    endtask

    task automatic rd_status(output logic [7:0] v);
        logic [7:0] d;
        cs_begin();
        xfer(8'h05, 8, -1, d);
        xfer(8'h00, 8, -1, v);
        cs_end();
    endtask

    task automatic wr_status(input logic [7:0] v);
        logic [7:0] d;
        cs_begin();
        xfer(8'h01, 8, -1, d);
        xfer(v, 8, -1, d);
        cs_end();
    endtask

    task automatic write1(input logic [15:0] a, input logic [7:0] v);
        logic [7:0] d;
        send_op(8'h06);
        cs_begin();
        xfer(8'h02, 8, -1, d);
        xfer(a[15:8], 8, -1, d);
        xfer(a[7:0], 8, -1, d);
        xfer(v, 8, -1, d);
        cs_end();
    endtask

    task automatic read1(input logic [15:0] a, output logic [7:0] v);
        logic [7:0] d;
        cs_begin();
        xfer(8'h03, 8, -1, d);
        xfer(a[15:8], 8, -1, d);
        xfer(a[7:0], 8, -1, d);
        xfer(8'h00, 8, -1, v);
        cs_end();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R14 actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [7:0] d;
        rst = 1'b1; sck = 1'b0; cs_n = 1'b1; si = 1'b0; wp_n = 1'b1; hold_n = 1'b1;
        tick(5);
        rst = 1'b0;
        tick(5);

        // reset state
        chk("R14 so_oe after reset", {31'd0, so_oe}, 32'd0);
        chk("R2 so_oe with cs_n high", {31'd0, so_oe}, 32'd0);
        rd_status(r);
        chk("R14 R12 status after reset", {24'd0, r}, 32'h00);
        read1(16'h0010, r);
        chk("R14 array erased", {24'd0, r}, 32'hFF);

        // vector table: write, check latch cleared, read back
        for (int i = 0; i < 6; i++) begin
            mode3 = VEC[i][24];
            write1(VEC[i][23:8], VEC[i][7:0]);
            rd_status(r);
            chk("R11 latch cleared after write", {24'd0, r}, 32'h00);
            read1(VEC[i][23:8], r);
            chk(mode3 ? "R1 R8 mode 3 readback" : "R1 R8 mode 0 readback",
                {24'd0, r}, {24'd0, VEC[i][7:0]});
        end
        mode3 = 1'b0;

        // R4: write without latch, and after clearing it
        cs_begin();
        xfer(8'h02, 8, -1, d); xfer(8'h00, 8, -1, d); xfer(8'h20, 8, -1, d);
        xfer(8'h5A, 8, -1, d);
        cs_end();
        read1(16'h0020, r);
        chk("R4 write without latch", {24'd0, r}, 32'hFF);
        send_op(8'h06);
        send_op(8'h04);
        rd_status(r);
        chk("R4 latch cleared by 0x04", {24'd0, r}, 32'h00);
        cs_begin();
        xfer(8'h02, 8, -1, d); xfer(8'h00, 8, -1, d); xfer(8'h20, 8, -1, d);
        xfer(8'h5A, 8, -1, d);
        cs_end();
        read1(16'h0020, r);
        chk("R4 write after clear", {24'd0, r}, 32'hFF);

        // R3: unknown command byte
        send_op(8'h06);
        cs_begin();
        xfer(8'h9C, 8, -1, d); xfer(8'h05, 8, -1, d); xfer(8'h04, 8, -1, d);
        cs_end();
        chk("R3 so undriven after unknown byte", {31'd0, oe_seen}, 32'd0);
        rd_status(r);
        chk("R3 status untouched by unknown byte", {24'd0, r}, 32'h02);

        // R10: partial final byte
        cs_begin();
        xfer(8'h02, 8, -1, d); xfer(8'h00, 8, -1, d); xfer(8'h30, 8, -1, d);
        xfer(8'h11, 8, -1, d); xfer(8'hFF, 4, -1, d);
        cs_end();
        read1(16'h0030, r);
        chk("R10 partial byte commits nothing", {24'd0, r}, 32'hFF);
        rd_status(r);
        chk("R10 latch kept after partial write", {24'd0, r}, 32'h02);
        send_op(8'h04);

        // R13: page cap, R8 streaming read
        send_op(8'h06);
        cs_begin();
        xfer(8'h02, 8, -1, d); xfer(8'h00, 8, -1, d); xfer(8'h40, 8, -1, d);
        for (int i = 0; i < PAGE_BYTES + 2; i++) xfer(8'h80 + 8'(i), 8, -1, d);
        cs_end();
        cs_begin();
        xfer(8'h03, 8, -1, d); xfer(8'h00, 8, -1, d); xfer(8'h40, 8, -1, d);
        for (int i = 0; i < PAGE_BYTES + 2; i++) begin
            xfer(8'h00, 8, -1, r);
            chk("R13 R8 page stream", {24'd0, r},
                (i < PAGE_BYTES) ? 32'h80 + 32'(i) : 32'hFF);
        end
        cs_end();

        // R9: wrap at end of array
        send_op(8'h06);
        cs_begin();
        xfer(8'h02, 8, -1, d); xfer(8'h00, 8, -1, d); xfer(8'(MAIN_BYTES - 1), 8, -1, d);
        xfer(8'hA5, 8, -1, d); xfer(8'h3C, 8, -1, d);
        cs_end();
        cs_begin();
        xfer(8'h03, 8, -1, d); xfer(8'h00, 8, -1, d); xfer(8'(MAIN_BYTES - 1), 8, -1, d);
        xfer(8'h00, 8, -1, r);
        chk("R9 last byte of array", {24'd0, r}, 32'hA5);
        xfer(8'h00, 8, -1, r);
        chk("R9 wrapped to address 0", {24'd0, r}, 32'h3C);
        cs_end();

        // R12: status repeats
        send_op(8'h06);
        cs_begin();
        xfer(8'h05, 8, -1, d);
        for (int i = 0; i < 3; i++) begin
            xfer(8'h00, 8, -1, r);
            chk("R12 repeated status byte", {24'd0, r}, 32'h02);
        end
        cs_end();

        // R7: identification page
        wr_status(8'h40);
        rd_status(r);
        chk("R7 R11 page select set, latch cleared", {24'd0, r}, 32'h40);
        read1(16'h0005, r);
        chk("R7 id page erased", {24'd0, r}, 32'hFF);
        write1(16'h0085, 8'h77);
        read1(16'h0005, r);
        chk("R7 id page indexed by low 7 bits", {24'd0, r}, 32'h77);
        send_op(8'h06);
        wr_status(8'h00);
        read1(16'h0005, r);
        chk("R7 main array untouched", {24'd0, r}, 32'hFF);

        // R5: protect lock, in mode 3
        mode3 = 1'b1;
        send_op(8'h06);
        wr_status(8'h80);
        rd_status(r);
        chk("R5 protect bit set", {24'd0, r}, 32'h80);
        wp_n = 1'b0;
        send_op(8'h06);
        wr_status(8'h00);
        rd_status(r);
        chk("R5 status locked with wp_n low", {24'd0, r}, 32'h82);
        wp_n = 1'b1;
        wr_status(8'h00);
        rd_status(r);
        chk("R5 status writable with wp_n high", {24'd0, r}, 32'h00);
        mode3 = 1'b0;

        // R6: pause inside address and data bytes
        write1(16'h0060, 8'hC3);
        cs_begin();
        xfer(8'h03, 8, -1, d); xfer(8'h00, 8, -1, d); xfer(8'h60, 8, 2, d);
        xfer(8'h00, 8, 5, r);
        chk("R6 byte intact across pause", {24'd0, r}, 32'hC3);
        chk("R2 so driven during read", {31'd0, oe_seen}, 32'd1);
        cs_end();
        chk("R2 so released after cs_n high", {31'd0, so_oe}, 32'd0);

        done = 1'b1;
        finish_run();
    end

endmodule